// File: doc/BRIEF.md
# Multi-Cycle 16-bit Register-Memory Processor

This block is a small sequential processor that executes programs out of one shared word-addressed memory holding both code and data. It has four 16-bit general-purpose registers and a 10-bit program counter. Every instruction goes through the same order of phases: a read of the instruction word, a latch of that word, and an execute phase. Instructions that read a data operand add a writeback phase. Arithmetic is 16-bit two's complement and any carry out of the top bit is dropped. The conditional branches test a register directly, either for zero or for a set sign bit. There is no flag register.

The instruction word splits into three fields. Bits 15:12 hold the operation, bits 11:10 select register Rn, and bits 9:0 hold a word address or a branch target. In the indirect forms, bits 1:0 of that address field name register Rm, and the low 10 bits of Rm are used as the data address. The memory port is synchronous and has a fixed latency: a read issued in one cycle returns its word in the next cycle, and a write takes effect at the clock edge where it is issued. Because the memory is always ready, the port has no back-pressure. The enable line qualifies each access, and the read/write line chooses the direction. Debug outputs show the program counter, all four registers and a halted flag.

Top module: `acc_cpu16`

## Requirements
- R1: While reset is low, the PC reads 0, all four registers read 0 and halted is 0. The first memory access after reset is a read (mem_we=0) at address 0.
- R2: Each instruction begins with a read at the PC, and the PC then advances by one. After a STOP at address k, dbg_pc reads k+1. The total number of memory accesses is the number of instructions fetched plus one for each instruction that reads or writes data.
- R3: Opcode 0001 (load) copies the word at the 10-bit address in bits 9:0 into register Rn (bits 11:10).
- R4: Opcode 0010 (store) writes Rn to the address in bits 9:0, with mem_we=1 and mem_en=1. Rn itself is unchanged.
- R5: Opcode 0011 sets Rn to Rn plus the memory word, and opcode 0100 sets Rn to Rn minus the memory word. Both are modulo 2^16, so 0x7FFF+1 gives 0x8000, 0xFFFF+1 gives 0 and 0-1 gives 0xFFFF.
- R6: Opcodes 1001, 1010, 1011 and 1100 are the load, store, add and subtract operations with the data address taken from the low 10 bits of register Rm. Rm is selected by bits 1:0, and bits 9:2 are ignored.
- R7: Opcode 0101 loads the PC with bits 9:0 unconditionally.
- R8: Opcode 0110 loads the PC with bits 9:0 when Rn is 0. Opcode 0111 does so when bit 15 of Rn is 1. Otherwise execution goes on at the next word.
- R9: Opcodes 1000, 1101, 1110 and 1111 change no register and make no memory access beyond their own fetch.
- R10: Opcode 0000 raises halted. From then until reset, halted stays high and mem_en stays low.
- R11: Counted from the release of reset, every instruction takes 3 clock cycles, except load and add/subtract (direct or indirect), which take 4. halted is high right after the third cycle of STOP.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| mem_en | output | 1 | Memory access this cycle |
| mem_we | output | 1 | 0 = read, 1 = write |
| mem_addr | output | 10 | Word address |
| mem_wdata | output | 16 | Write data |
| mem_rdata | input | 16 | Read data, valid the cycle after a read |
| halted | output | 1 | Processor stopped |
| dbg_pc | output | 10 | Program counter |
| dbg_regs | output | 64 | Registers, R0 in bits 15:0 up to R3 in bits 63:48 |

## Verification
Register results from load and add/subtract land at the edge that ends the fourth cycle of the instruction. A store is in memory at the edge that ends its third cycle. A taken branch updates the PC at that same third edge. The bench does not sample mid-program. It counts rising edges from the release of reset until halted reads high on a falling edge, compares that count with the cycle total of its own instruction-level model, and then compares registers, PC, memory image and access count once the machine has stopped. Twenty extra cycles after the halt confirm that the machine stays silent.

// File: rtl/acc_cpu16_pkg.sv
package acc_cpu16_pkg;
  localparam int OPW = 4;

  localparam logic [OPW-1:0] OP_STOP = 4'h0;
  localparam logic [OPW-1:0] OP_LDD  = 4'h1;
  localparam logic [OPW-1:0] OP_STD  = 4'h2;
  localparam logic [OPW-1:0] OP_ADDD = 4'h3;
  localparam logic [OPW-1:0] OP_SUBD = 4'h4;
  localparam logic [OPW-1:0] OP_JMP  = 4'h5;
  localparam logic [OPW-1:0] OP_JZ   = 4'h6;
  localparam logic [OPW-1:0] OP_JN   = 4'h7;
  localparam logic [OPW-1:0] OP_LDI  = 4'h9;
  localparam logic [OPW-1:0] OP_STI  = 4'hA;
  localparam logic [OPW-1:0] OP_ADDI = 4'hB;
  localparam logic [OPW-1:0] OP_SUBI = 4'hC;

  typedef enum logic [2:0] {
    S_FETCH = 3'd0,
    S_LATCH = 3'd1,
    S_EXEC  = 3'd2,
    S_WBACK = 3'd3,
    S_HALT  = 3'd4
  } phase_e;

  typedef struct packed {
    logic stop;
    logic load;
    logic add;
    logic sub;
    logic store;
    logic indir;
    logic jmp;
    logic jz;
    logic jn;
    logic nop;
  } dec_t;
endpackage

// File: rtl/acc_cpu16_decode.sv
module acc_cpu16_decode
  import acc_cpu16_pkg::*;
(
  input  logic [OPW-1:0] op,
  output dec_t           dec
);
  always_comb begin
    dec = '0;
    case (op)
      OP_STOP: dec.stop = 1'b1;
      OP_LDD:  dec.load = 1'b1;
      OP_STD:  dec.store = 1'b1;
      OP_ADDD: dec.add = 1'b1;
      OP_SUBD: dec.sub = 1'b1;
      OP_JMP:  dec.jmp = 1'b1;
      OP_JZ:   dec.jz = 1'b1;
      OP_JN:   dec.jn = 1'b1;
      OP_LDI:  begin dec.load = 1'b1;  dec.indir = 1'b1; end
      OP_STI:  begin dec.store = 1'b1; dec.indir = 1'b1; end
      OP_ADDI: begin dec.add = 1'b1;   dec.indir = 1'b1; end
      OP_SUBI: begin dec.sub = 1'b1;   dec.indir = 1'b1; end
      default: dec.nop = 1'b1;
    endcase
  end
endmodule

// File: rtl/acc_cpu16_alu.sv
module acc_cpu16_alu #(
  parameter int DW = 16
) (
  input  logic [DW-1:0] a,
  input  logic [DW-1:0] b,
  input  logic          sub,
  output logic [DW-1:0] y
);
  logic [DW-1:0] b_eff;
  assign b_eff = sub ? ~b : b;
  // carry out of the top bit falls off the DW-bit sum
  assign y = a + b_eff + {{(DW-1){1'b0}}, sub};
endmodule

// File: rtl/acc_cpu16_regfile.sv
module acc_cpu16_regfile #(
  parameter int DW   = 16,
  parameter int NREG = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               we,
  input  logic [RW-1:0]      wsel,
  input  logic [DW-1:0]      wdata,
  input  logic [RW-1:0]      sel_a,
  output logic [DW-1:0]      rd_a,
  input  logic [RW-1:0]      sel_b,
  output logic [DW-1:0]      rd_b,
  output logic [NREG*DW-1:0] flat
);
  localparam int RW = $clog2(NREG);

  logic [DW-1:0] regs [NREG];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) regs[i] <= '0;
    end else if (we) begin
      regs[wsel] <= wdata;
    end
  end

  assign rd_a = regs[sel_a];
  assign rd_b = regs[sel_b];

  for (genvar g = 0; g < NREG; g++) begin : g_flat
    assign flat[g*DW +: DW] = regs[g];
  end

  // R3: a write lands in the selected register one edge later
  p_wb_lands_r3: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> regs[$past(wsel)] == $past(wdata));
endmodule

// File: rtl/acc_cpu16.sv
module acc_cpu16
  import acc_cpu16_pkg::*;
#(
  parameter int DW   = 16,
  parameter int AW   = 10,
  parameter int NREG = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  output logic               mem_en,
  output logic               mem_we,
  output logic [AW-1:0]      mem_addr,
  output logic [DW-1:0]      mem_wdata,
  input  logic [DW-1:0]      mem_rdata,
  output logic               halted,
  output logic [AW-1:0]      dbg_pc,
  output logic [NREG*DW-1:0] dbg_regs
);
  localparam int RW = $clog2(NREG);

  phase_e        state;
  logic [AW-1:0] pc;
  logic [DW-1:0] ir;

  logic [OPW-1:0] f_op;
  logic [RW-1:0]  f_rn;
  logic [RW-1:0]  f_rm;
  logic [AW-1:0]  f_addr;
  assign f_op   = ir[DW-1 -: OPW];
  assign f_rn   = ir[AW+RW-1 : AW];
  assign f_rm   = ir[RW-1:0];
  assign f_addr = ir[AW-1:0];

  dec_t dec;
  acc_cpu16_decode u_dec (.op(f_op), .dec(dec));

  logic          rf_we;
  logic [DW-1:0] rf_wdata;
  logic [DW-1:0] ra;
  logic [DW-1:0] rb;
  acc_cpu16_regfile #(.DW(DW), .NREG(NREG)) u_rf (
    .clk(clk), .rst_n(rst_n),
    .we(rf_we), .wsel(f_rn), .wdata(rf_wdata),
    .sel_a(f_rn), .rd_a(ra),
    .sel_b(f_rm), .rd_b(rb),
    .flat(dbg_regs)
  );

  logic [DW-1:0] alu_y;
  acc_cpu16_alu #(.DW(DW)) u_alu (
    .a(ra), .b(mem_rdata), .sub(dec.sub), .y(alu_y)
  );

  logic unused_hi;
  assign unused_hi = ^rb[DW-1:AW];

  logic [AW-1:0] ea;
  assign ea = dec.indir ? rb[AW-1:0] : f_addr;

  logic take;
  assign take = dec.jmp
              | (dec.jz && (ra == '0))
              | (dec.jn && ra[DW-1]);

  logic rd_op;
  assign rd_op = dec.load | dec.add | dec.sub;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= S_FETCH;
      pc    <= '0;
      ir    <= '0;
    end else begin
      case (state)
        S_FETCH: begin
          pc    <= pc + AW'(1);
          state <= S_LATCH;
        end
        S_LATCH: begin
          ir    <= mem_rdata;
          state <= S_EXEC;
        end
        S_EXEC: begin
          if (dec.stop)      state <= S_HALT;
          else if (rd_op)    state <= S_WBACK;
          else               state <= S_FETCH;
          if (take) pc <= f_addr;
        end
        S_WBACK: state <= S_FETCH;
        default: state <= S_HALT;
      endcase
    end
  end

  always_comb begin
    mem_en    = 1'b0;
    mem_we    = 1'b0;
    mem_addr  = pc;
    mem_wdata = ra;
    rf_we     = 1'b0;
    rf_wdata  = dec.load ? mem_rdata : alu_y;
    case (state)
      S_FETCH: mem_en = 1'b1;
      S_EXEC: begin
        mem_addr = ea;
        mem_en   = rd_op | dec.store;
        mem_we   = dec.store;
      end
      S_WBACK: rf_we = 1'b1;
      default: ;
    endcase
  end

  assign halted = (state == S_HALT);
  assign dbg_pc = pc;

  // R10: once stopped, the memory port is idle and the stop is sticky
  p_halt_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    halted |-> !mem_en);
  p_halt_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    halted |=> halted);
  // R2: every fetch advances the PC by one
  p_pc_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_FETCH) |=> pc == $past(pc) + AW'(1));
  // R4: only a decoded store in execute ever writes memory
  p_write_only_store_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_en && mem_we) |-> (dec.store && state == S_EXEC));
  // R7: unconditional jump lands on the address field
  p_jump_target_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_EXEC && dec.jmp) |=> pc == $past(f_addr));
  // R8: zero test with a non-zero register leaves the PC alone
  p_jz_not_taken_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_EXEC && dec.jz && ra != '0) |=> $stable(pc));
  // R9: no-operation codes never touch memory in execute
  p_nop_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_EXEC && dec.nop) |-> !mem_en);
  // R9: no-operation codes leave every register as it was
  p_nop_regs_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_EXEC && dec.nop) |=> $stable(dbg_regs));
endmodule

// File: tb/test_acc_cpu16.sv
module test_acc_cpu16;
  localparam int DW = 16;
  localparam int AW = 10;
  localparam int NREG = 4;
  localparam int MEMW = 1 << AW;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic               mem_en, mem_we, halted;
  logic [AW-1:0]      mem_addr, dbg_pc;
  logic [DW-1:0]      mem_wdata;
  logic [DW-1:0]      mem_rdata = '0;
  logic [NREG*DW-1:0] dbg_regs;

  acc_cpu16 #(.DW(DW), .AW(AW), .NREG(NREG)) i_acc_cpu16 (
    .clk(clk), .rst_n(rst_n),
    .mem_en(mem_en), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .halted(halted), .dbg_pc(dbg_pc), .dbg_regs(dbg_regs)
  );

  logic [DW-1:0] img [MEMW];
  logic [DW-1:0] mem [MEMW];
  logic [DW-1:0] ref_mem [MEMW];
  logic [DW-1:0] mr [NREG];
  logic [AW-1:0] mpc;

  int acc_cnt, halt_acc;
  bit first_seen;
  logic [AW-1:0] first_addr;
  logic first_we;

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < MEMW; i++) mem[i] <= img[i];
      acc_cnt = 0; halt_acc = 0; first_seen = 0;
    end else if (mem_en) begin
      if (mem_we) mem[mem_addr] <= mem_wdata;
      else        mem_rdata <= mem[mem_addr];
      acc_cnt++;
      if (halted) halt_acc++;
      if (!first_seen) begin
        first_seen = 1; first_addr = mem_addr; first_we = mem_we;
      end
    end
  end

  int total = 0;
  int bad = 0;

  task automatic check(bit ok, string req, string what, longint act, longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s act=%0h exp=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] mk(int op, int rn, int a);
    return {op[3:0], rn[1:0], a[9:0]};
  endfunction

  function automatic logic [DW-1:0] reg_of(int i);
    return dbg_regs[i*DW +: DW];
  endfunction

  // instruction-level model: returns expected cycles and memory accesses
  task automatic model_run(output int cyc, output int acc, output bit ok);
    logic [DW-1:0] w;
    logic [3:0] op;
    int rn, rm;
    logic [AW-1:0] fa, ea;
    cyc = 0; acc = 0; ok = 0;
    for (int i = 0; i < MEMW; i++) ref_mem[i] = img[i];
    for (int i = 0; i < NREG; i++) mr[i] = '0;
    mpc = '0;
    for (int step = 0; step < 3000 && !ok; step++) begin
      w = ref_mem[mpc];
      mpc = mpc + 10'd1;
      acc++; cyc += 3;
      op = w[15:12]; rn = int'(w[11:10]); rm = int'(w[1:0]); fa = w[9:0];
      ea = op[3] ? mr[rm][AW-1:0] : fa;
      case (op)
        4'h0: ok = 1;
        4'h1, 4'h9: begin mr[rn] = ref_mem[ea]; cyc++; acc++; end
        4'h2, 4'hA: begin ref_mem[ea] = mr[rn]; acc++; end
        4'h3, 4'hB: begin mr[rn] = mr[rn] + ref_mem[ea]; cyc++; acc++; end
        4'h4, 4'hC: begin mr[rn] = mr[rn] - ref_mem[ea]; cyc++; acc++; end
        4'h5: mpc = fa;
        4'h6: if (mr[rn] == '0) mpc = fa;
        4'h7: if (mr[rn][15]) mpc = fa;
        default: ;
      endcase
    end
  endtask

  int last_cyc;

  task automatic run_prog(string name);
    int ecyc, eacc, cyc, mis;
    bit ok;
    model_run(ecyc, eacc, ok);
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(dbg_pc == '0 && dbg_regs == '0 && !halted, "R1", {name, " reset state"},
          {dbg_pc, halted}, 0);
    rst_n = 1'b1;
    cyc = 0;
    while (!halted && cyc < 20000) begin
      @(posedge clk); cyc++; @(negedge clk);
    end
    last_cyc = cyc;
    check(halted, "R10", {name, " halted"}, halted, 1);
    check(cyc == ecyc, "R11", {name, " cycles"}, cyc, ecyc);
    check(first_addr == '0 && !first_we, "R1", {name, " first access"},
          {first_we, first_addr}, 0);
    for (int i = 0; i < NREG; i++)
      check(reg_of(i) == mr[i], "R3", {name, " register"}, reg_of(i), mr[i]);
    check(dbg_pc == mpc, "R2", {name, " final pc"}, dbg_pc, mpc);
    check(acc_cnt == eacc, "R2", {name, " access count"}, acc_cnt, eacc);
    mis = -1;
    for (int i = 0; i < MEMW; i++) if (mis < 0 && mem[i] !== ref_mem[i]) mis = i;
    check(mis < 0, "R4", {name, " memory image"}, mis, -1);
    repeat (20) @(negedge clk);
    check(halted && halt_acc == 0, "R10", {name, " quiet after stop"}, halt_acc, 0);
  endtask

  task automatic clear_img();
    for (int i = 0; i < MEMW; i++) img[i] = '0;
  endtask

  task automatic mult_prog(logic [15:0] b, logic [15:0] c);
    clear_img();
    img[10'h301] = b; img[10'h302] = c; img[10'h304] = 16'd1;
    img[10'h300] = 16'hDEAD;
    img[0] = mk(1, 1, 'h303);
    img[1] = mk(1, 2, 'h302);
    img[2] = mk(6, 2, 7);
    img[3] = mk(7, 2, 7);
    img[4] = mk(3, 1, 'h301);
    img[5] = mk(4, 2, 'h304);
    img[6] = mk(5, 0, 2);
    img[7] = mk(2, 1, 'h300);
    img[8] = mk(0, 0, 0);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    clear_img();

    // arithmetic wrap, direct load and store
    img[600] = 16'h7FFF; img[601] = 16'h0001; img[602] = 16'hFFFF; img[603] = 16'h0000;
    img[0] = mk(1, 0, 600); img[1] = mk(3, 0, 601);
    img[2] = mk(1, 1, 602); img[3] = mk(3, 1, 601);
    img[4] = mk(1, 2, 603); img[5] = mk(4, 2, 601);
    img[6] = mk(2, 0, 700); img[7] = mk(2, 2, 701);
    img[8] = mk(0, 0, 0);
    run_prog("arith");
    check(reg_of(0) == 16'h8000, "R5", "0x7FFF+1", reg_of(0), 16'h8000);
    check(reg_of(1) == 16'h0000, "R5", "0xFFFF+1", reg_of(1), 0);
    check(reg_of(2) == 16'hFFFF, "R5", "0-1", reg_of(2), 16'hFFFF);
    check(mem[700] == 16'h8000 && reg_of(0) == 16'h8000, "R4", "store keeps Rn",
          mem[700], 16'h8000);
    check(last_cyc == 33, "R11", "arith cycle total", last_cyc, 33);
    check(dbg_pc == 10'd9, "R2", "pc after stop", dbg_pc, 9);

    // register-indirect forms, address field upper bits ignored
    clear_img();
    img[600] = 16'h1234; img[610] = 16'hFE58; img[611] = 16'h02BC;
    img[0] = mk(1, 3, 610);
    img[1] = mk(9, 1, 10'h3FF);
    img[2] = mk(11, 1, 10'h0A7);
    img[3] = mk(12, 1, 3);
    img[4] = mk(1, 2, 611);
    img[5] = mk(10, 1, 10'h2C2);
    img[6] = mk(0, 0, 0);
    run_prog("indirect");
    check(reg_of(1) == 16'h1234, "R6", "load/add/sub via Rm", reg_of(1), 16'h1234);
    check(mem[700] == 16'h1234, "R6", "store via Rm", mem[700], 16'h1234);

    // branches
    clear_img();
    img[600] = 16'h0000; img[601] = 16'h0077; img[602] = 16'h8001; img[603] = 16'h0042;
    img[0] = mk(1, 0, 600); img[1] = mk(6, 0, 3);  img[2] = mk(1, 1, 601);
    img[3] = mk(1, 2, 602); img[4] = mk(7, 2, 6);  img[5] = mk(1, 1, 601);
    img[6] = mk(6, 2, 8);   img[7] = mk(1, 3, 603); img[8] = mk(7, 3, 10);
    img[9] = mk(5, 0, 11);  img[10] = mk(1, 1, 601); img[11] = mk(0, 0, 0);
    run_prog("branch");
    check(reg_of(1) == 16'h0000, "R7", "taken branches skip loads", reg_of(1), 0);
    check(reg_of(3) == 16'h0042, "R8", "untaken tests fall through", reg_of(3), 16'h42);
    check(dbg_pc == 10'd12, "R8", "branch pc", dbg_pc, 12);

    // no-operation codes
    clear_img();
    img[0] = mk(8, 1, 600); img[1] = mk(13, 2, 601);
    img[2] = mk(14, 3, 602); img[3] = mk(15, 0, 603);
    img[4] = mk(0, 0, 0);
    run_prog("nop");
    check(dbg_regs == '0 && acc_cnt == 5, "R9", "nops untouched", acc_cnt, 5);
    check(last_cyc == 15, "R9", "nop cycle total", last_cyc, 15);

    // multiply by repeated addition
    mult_prog(16'd7, 16'd13);
    run_prog("mul7x13");
    check(mem[10'h300] == 16'd91, "R5", "product 7*13", mem[10'h300], 91);
    mult_prog(16'd9, 16'd0);
    run_prog("mul9x0");
    check(mem[10'h300] == 16'd0, "R8", "product with zero count", mem[10'h300], 0);
    mult_prog(16'd5, 16'hFFFD);
    run_prog("mul_neg");
    check(mem[10'h300] == 16'd0, "R8", "negative count exits", mem[10'h300], 0);
    mult_prog(16'hFFFE, 16'd3);
    run_prog("mul_negb");
    check(mem[10'h300] == 16'hFFFA, "R5", "product -2*3", mem[10'h300], 16'hFFFA);

    // constrained random programs
    for (int p = 0; p < 40; p++) begin
      int ecyc, eacc, n;
      bit ok;
      ok = 0;
      n = 24;
      while (!ok) begin
        for (int i = 0; i < MEMW; i++) img[i] = DW'($urandom);
        for (int a = 0; a < n; a++) begin
          int op, rn, ad;
          op = int'($urandom_range(1, 15));
          rn = int'($urandom_range(0, 3));
          if (op >= 5 && op <= 7)      ad = int'($urandom_range(a + 1, n));
          else if (op >= 1 && op <= 4) ad = int'($urandom_range(512, 1023));
          else                         ad = int'($urandom_range(0, 1023));
          img[a] = mk(op, rn, ad);
        end
        img[n] = mk(0, 0, 0);
        model_run(ecyc, eacc, ok);
      end
      run_prog($sformatf("rand%0d", p));
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(8 * 150000);
    total++; bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule